// File: doc/BRIEF.md
# BCD Clock Calendar Counter

This block keeps wall-clock time and calendar date as packed BCD bytes: seconds, minutes, hours, day of week, day of month, month and two-digit year. A free-running enable at 32.768 kHz feeds a sub-second prescaler. When the prescaler wraps it issues a one-second tick, and that tick advances the counter chain. Carries run from seconds up to the year. The date field wraps at the correct end of each month, and February has 29 days in leap years.

Software reaches every field through a small register port. A write replaces only the addressed byte, and counting carries on around it. A read returns any byte combinationally. The hour byte holds its own format select, so the same counter runs either 00–23 or 01–12 with an AM/PM flag. A run/stop bit in a control byte freezes the prescaler and the counters. This bit comes up set after reset. Writing the seconds byte restarts the prescaler, so the first tick after the write arrives a whole second later.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the fields read seconds 00, minutes 00, hour 00 (24-hour), weekday 1, date 01, month 01 and year 00. The control byte at address 7 reads 80h, which means stopped.
- R2: Each tick advances the seconds byte (address 0) by one in BCD. A tick at 59 gives 00 and carries into the minutes byte (address 1).
- R3: A carry into minutes at 59 gives 00 and carries into the hour byte (address 2).
- R4: With hour bit 6 clear (24-hour mode), the hour runs 00–23. A carry at 23 gives 00 and advances both the date (address 4) and the weekday (address 3).
- R5: With hour bit 6 set (12-hour mode), bits 4:0 hold the BCD hour 01–12 and bit 5 is PM. Going from 11 to 12 flips bit 5. Going from 12 to 01 keeps bit 5. The date advances only on the 11 PM to 12 AM step.
- R6: The date wraps to 01 after 30 in months 04, 06, 09 and 11, and after 31 in the other months other than February. The wrap advances the month (address 5).
- R7: In month 02 the date wraps after 29 when the BCD year is divisible by four, and after 28 otherwise.
- R8: Month 12 wraps to 01 and advances the year (address 6). The year wraps from 99 to 00.
- R9: The weekday runs 1 to 7 and wraps to 1 at midnight.
- R10: While running, a tick occurs on every 2^PRESC_W-th enable pulse, and no tick occurs on any other enable.
- R11: Control bit 7 set to 1 stops the prescaler and all counting. The bit reads back as written, and clearing it resumes counting where it stopped.
- R12: Writing the seconds byte clears the prescaler. The next tick then needs a full 2^PRESC_W enables.
- R13: A write replaces only the addressed field. If a tick arrives in the same cycle, the write wins for that field and every other field still advances.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_en_i | input | 1 | One-cycle enable at the 32.768 kHz rate |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register address: 0 sec, 1 min, 2 hour, 3 weekday, 4 date, 5 month, 6 year, 7 control |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i, combinational |
| sec_tick_o | output | 1 | One-cycle pulse when a second elapses |

## Verification
The assertions assume that software writes only legal BCD values in every field, because out-of-range bytes have no defined successor. They also assume that osc_en_i never stays high longer than the bench drives it. The stimulus sets time only through whole-field writes of legal values. It writes the seconds byte last, so each scenario starts from a cleared prescaler. It then advances time only in counted bursts of enable pulses, which makes the exact tick cycle known.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  typedef enum logic [2:0] {
    RA_SEC   = 3'd0,
    RA_MIN   = 3'd1,
    RA_HOUR  = 3'd2,
    RA_WDAY  = 3'd3,
    RA_DATE  = 3'd4,
    RA_MONTH = 3'd5,
    RA_YEAR  = 3'd6,
    RA_CTRL  = 3'd7
  } rtc_addr_e;

  localparam int HALT_BIT   = 7;
  localparam int H12_BIT    = 6;
  localparam int PM_BIT     = 5;

  // BCD +1 on a two-digit byte; callers handle field wrap
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] == 4'd9) r = {v[7:4] + 4'd1, 4'd0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // BCD year divisible by four
  function automatic logic year_is_leap(input logic [7:0] y);
    logic u048, u26;
    u048 = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    u26  = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    return y[4] ? u26 : u048;
  endfunction

  function automatic logic [7:0] month_last_day(input logic [7:0] m,
                                                input logic       leap);
    logic [7:0] r;
    case (m)
      8'h02:                      r = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: r = 8'h30;
      default:                    r = 8'h31;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int PRESC_W = 15
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               osc_en_i,
  input  logic               halt_i,
  input  logic               clear_i,
  output logic               tick_o,
  output logic [PRESC_W-1:0] cnt_o
);

  localparam logic [PRESC_W-1:0] CNT_LAST = '1;

  logic [PRESC_W-1:0] cnt_q, cnt_d;
  logic               step;

  assign step = osc_en_i && !halt_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i)   cnt_d = '0;
    else if (step) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tick_o = step && !clear_i && (cnt_q == CNT_LAST);
  assign cnt_o  = cnt_q;

endmodule

// File: rtl/rtc_time_counter.sv
module rtc_time_counter
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick_i,
  input  logic       wr_sec_i,
  input  logic       wr_min_i,
  input  logic       wr_hour_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] sec_o,
  output logic [7:0] min_o,
  output logic [7:0] hour_o,
  output logic       day_roll_o
);

  logic [7:0] sec_q, sec_d;
  logic [7:0] min_q, min_d;
  logic [7:0] hour_q, hour_d;
  logic [7:0] hour_adv;
  logic       hour_midnight;
  logic       sec_wrap, min_wrap;
  logic       min_step, hour_step;

  assign sec_wrap  = (sec_q == 8'h59);
  assign min_wrap  = (min_q == 8'h59);
  assign min_step  = tick_i && sec_wrap;
  assign hour_step = min_step && min_wrap;

  // successor of the hour byte in either format
  always_comb begin
    logic [7:0] hr;
    logic [7:0] inc;
    hour_adv      = hour_q;
    hour_midnight = 1'b0;
    if (hour_q[H12_BIT]) begin
      hr  = {3'b000, hour_q[4:0]};
      inc = bcd_inc(hr);
      if (hr == 8'h11) begin
        hour_adv      = {1'b0, 1'b1, ~hour_q[PM_BIT], 5'h12};
        hour_midnight = hour_q[PM_BIT];
      end else if (hr == 8'h12) begin
        hour_adv = {1'b0, 1'b1, hour_q[PM_BIT], 5'h01};
      end else begin
        hour_adv = {1'b0, 1'b1, hour_q[PM_BIT], inc[4:0]};
      end
    end else begin
      hr  = {2'b00, hour_q[5:0]};
      inc = bcd_inc(hr);
      if (hr == 8'h23) begin
        hour_adv      = 8'h00;
        hour_midnight = 1'b1;
      end else begin
        hour_adv = {2'b00, inc[5:0]};
      end
    end
  end

  always_comb begin
    sec_d  = sec_q;
    min_d  = min_q;
    hour_d = hour_q;
    if (tick_i)    sec_d  = sec_wrap ? 8'h00 : bcd_inc(sec_q);
    if (min_step)  min_d  = min_wrap ? 8'h00 : bcd_inc(min_q);
    if (hour_step) hour_d = hour_adv;
    if (wr_sec_i)  sec_d  = wdata_i;
    if (wr_min_i)  min_d  = wdata_i;
    if (wr_hour_i) hour_d = {1'b0, wdata_i[6:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_q  <= 8'h00;
      min_q  <= 8'h00;
      hour_q <= 8'h00;
    end else begin
      sec_q  <= sec_d;
      min_q  <= min_d;
      hour_q <= hour_d;
    end
  end

  assign sec_o      = sec_q;
  assign min_o      = min_q;
  assign hour_o     = hour_q;
  assign day_roll_o = hour_step && hour_midnight;

endmodule

// File: rtl/rtc_date_counter.sv
module rtc_date_counter
  import rtc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       day_roll_i,
  input  logic       wr_wday_i,
  input  logic       wr_date_i,
  input  logic       wr_month_i,
  input  logic       wr_year_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] wday_o,
  output logic [7:0] date_o,
  output logic [7:0] month_o,
  output logic [7:0] year_o
);

  logic [2:0] wday_q, wday_d;
  logic [7:0] date_q, date_d;
  logic [7:0] month_q, month_d;
  logic [7:0] year_q, year_d;
  logic [7:0] last_day;
  logic       date_wrap, month_wrap;
  logic       month_step, year_step;

  assign last_day   = month_last_day(month_q, year_is_leap(year_q));
  assign date_wrap  = (date_q == last_day);
  assign month_wrap = (month_q == 8'h12);
  assign month_step = day_roll_i && date_wrap;
  assign year_step  = month_step && month_wrap;

  always_comb begin
    wday_d  = wday_q;
    date_d  = date_q;
    month_d = month_q;
    year_d  = year_q;
    if (day_roll_i) begin
      wday_d = (wday_q == 3'd7) ? 3'd1 : wday_q + 3'd1;
      date_d = date_wrap ? 8'h01 : bcd_inc(date_q);
    end
    if (month_step) month_d = month_wrap ? 8'h01 : bcd_inc(month_q);
    if (year_step)  year_d  = (year_q == 8'h99) ? 8'h00 : bcd_inc(year_q);
    if (wr_wday_i)  wday_d  = wdata_i[2:0];
    if (wr_date_i)  date_d  = wdata_i;
    if (wr_month_i) month_d = wdata_i;
    if (wr_year_i)  year_d  = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wday_q  <= 3'd1;
      date_q  <= 8'h01;
      month_q <= 8'h01;
      year_q  <= 8'h00;
    end else begin
      wday_q  <= wday_d;
      date_q  <= date_d;
      month_q <= month_d;
      year_q  <= year_d;
    end
  end

  assign wday_o  = {5'b00000, wday_q};
  assign date_o  = date_q;
  assign month_o = month_q;
  assign year_o  = year_q;

endmodule

// File: rtl/rtc_bcd_calendar.sv
module rtc_bcd_calendar
  import rtc_pkg::*;
#(
  parameter int PRESC_W = 15
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_en_i,
  input  logic       reg_wr_i,
  input  logic [2:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       sec_tick_o
);

  localparam int NUM_REGS = 8;

  logic [NUM_REGS-1:0] wr_sel;
  logic                halt_q, halt_d;
  logic                sec_wr;
  logic                tick_w;
  logic                day_roll_w;
  logic [PRESC_W-1:0]  presc_cnt_w;
  logic [7:0] sec_w, min_w, hour_w, wday_w, date_w, month_w, year_w;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_wsel
    assign wr_sel[i] = reg_wr_i && (reg_addr_i == i[2:0]);
  end

  assign sec_wr = wr_sel[RA_SEC];

  always_comb begin
    halt_d = halt_q;
    if (wr_sel[RA_CTRL]) halt_d = reg_wdata_i[HALT_BIT];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt_q <= 1'b1;
    else        halt_q <= halt_d;
  end

  rtc_prescaler #(.PRESC_W(PRESC_W)) u_presc (
    .clk      (clk),
    .rst_n    (rst_n),
    .osc_en_i (osc_en_i),
    .halt_i   (halt_q),
    .clear_i  (sec_wr),
    .tick_o   (tick_w),
    .cnt_o    (presc_cnt_w)
  );

  rtc_time_counter u_time (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick_i     (tick_w),
    .wr_sec_i   (sec_wr),
    .wr_min_i   (wr_sel[RA_MIN]),
    .wr_hour_i  (wr_sel[RA_HOUR]),
    .wdata_i    (reg_wdata_i),
    .sec_o      (sec_w),
    .min_o      (min_w),
    .hour_o     (hour_w),
    .day_roll_o (day_roll_w)
  );

  rtc_date_counter u_date (
    .clk        (clk),
    .rst_n      (rst_n),
    .day_roll_i (day_roll_w),
    .wr_wday_i  (wr_sel[RA_WDAY]),
    .wr_date_i  (wr_sel[RA_DATE]),
    .wr_month_i (wr_sel[RA_MONTH]),
    .wr_year_i  (wr_sel[RA_YEAR]),
    .wdata_i    (reg_wdata_i),
    .wday_o     (wday_w),
    .date_o     (date_w),
    .month_o    (month_w),
    .year_o     (year_w)
  );

  always_comb begin
    case (rtc_addr_e'(reg_addr_i))
      RA_SEC:   reg_rdata_o = sec_w;
      RA_MIN:   reg_rdata_o = min_w;
      RA_HOUR:  reg_rdata_o = hour_w;
      RA_WDAY:  reg_rdata_o = wday_w;
      RA_DATE:  reg_rdata_o = date_w;
      RA_MONTH: reg_rdata_o = month_w;
      RA_YEAR:  reg_rdata_o = year_w;
      default:  reg_rdata_o = {halt_q, 7'b0000000};
    endcase
  end

  assign sec_tick_o = tick_w;

endmodule

// File: rtl/rtc_bcd_calendar_chk.sv
module rtc_bcd_calendar_chk #(
  parameter int PRESC_W = 15
) (
  input logic               clk,
  input logic               rst_n,
  input logic               osc_en_i,
  input logic               reg_wr_i,
  input logic               tick,
  input logic               halt,
  input logic               sec_wr,
  input logic [PRESC_W-1:0] presc_cnt,
  input logic [7:0]         sec,
  input logic [7:0]         min,
  input logic [7:0]         hour,
  input logic [7:0]         wday,
  input logic [7:0]         date,
  input logic [7:0]         month,
  input logic [7:0]         year
);

  p_tick_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (osc_en_i && !halt));

  p_hold_when_halted_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !reg_wr_i) |=> ($stable(sec) && $stable(min) && $stable(hour)));

  p_presc_clear_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sec_wr |=> (presc_cnt == '0));

  p_presc_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (osc_en_i && !halt && !sec_wr) |=>
      (presc_cnt == PRESC_W'($past(presc_cnt) + 1'b1)));

  p_sec_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !reg_wr_i && sec == 8'h59) |=> (sec == 8'h00));

  p_cal_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !reg_wr_i) |=>
      ($stable(date) && $stable(month) && $stable(year) && $stable(wday)));

endmodule

bind rtc_bcd_calendar rtc_bcd_calendar_chk #(.PRESC_W(PRESC_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .osc_en_i  (osc_en_i),
  .reg_wr_i  (reg_wr_i),
  .tick      (tick_w),
  .halt      (halt_q),
  .sec_wr    (sec_wr),
  .presc_cnt (presc_cnt_w),
  .sec       (sec_w),
  .min       (min_w),
  .hour      (hour_w),
  .wday      (wday_w),
  .date      (date_w),
  .month     (month_w),
  .year      (year_w)
);

// File: tb/tb_rtc_bcd_calendar.sv
module tb_rtc_bcd_calendar;

  localparam int PW  = 3;
  localparam int TPS = 1 << PW;

  logic       clk;
  logic       rst_n;
  logic       osc_en;
  logic       wr;
  logic [2:0] addr;
  logic [7:0] wdata;
  logic [7:0] rdata;
  logic       tick;

  int n_chk  = 0;
  int n_fail = 0;

  rtc_bcd_calendar #(.PRESC_W(PW)) dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .osc_en_i    (osc_en),
    .reg_wr_i    (wr),
    .reg_addr_i  (addr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata),
    .sec_tick_o  (tick)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input logic [2:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s addr %0d actual %02h expected %02h", tag, a, rdata, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic run_en(input int n);
    @(negedge clk);
    osc_en = 1'b1;
    repeat (n) @(posedge clk);
    @(negedge clk);
    osc_en = 1'b0;
  endtask

  task automatic set_time(input logic [7:0] h, input logic [7:0] m, input logic [7:0] s,
                          input logic [7:0] wd, input logic [7:0] dt,
                          input logic [7:0] mo, input logic [7:0] yr);
    wr_reg(3'd7, 8'h00);
    wr_reg(3'd6, yr);
    wr_reg(3'd5, mo);
    wr_reg(3'd4, dt);
    wr_reg(3'd3, wd);
    wr_reg(3'd2, h);
    wr_reg(3'd1, m);
    wr_reg(3'd0, s);
  endtask

  task automatic t_reset;
    check(3'd0, 8'h00, "R1 sec");
    check(3'd1, 8'h00, "R1 min");
    check(3'd2, 8'h00, "R1 hour");
    check(3'd3, 8'h01, "R1 wday");
    check(3'd4, 8'h01, "R1 date");
    check(3'd5, 8'h01, "R1 month");
    check(3'd6, 8'h00, "R1 year");
    check(3'd7, 8'h80, "R1 ctrl");
  endtask

  task automatic t_seconds;
    set_time(8'h00, 8'h00, 8'h58, 8'h01, 8'h01, 8'h01, 8'h00);
    run_en(TPS - 1);
    check(3'd0, 8'h58, "R10 no tick early");
    run_en(1);
    check(3'd0, 8'h59, "R2 sec step");
    run_en(TPS);
    check(3'd0, 8'h00, "R2 sec wrap");
    check(3'd1, 8'h01, "R2 min carry");
  endtask

  task automatic t_minute_carry;
    set_time(8'h09, 8'h59, 8'h59, 8'h02, 8'h10, 8'h06, 8'h30);
    run_en(TPS);
    check(3'd1, 8'h00, "R3 min wrap");
    check(3'd2, 8'h10, "R3 hour carry");
    check(3'd4, 8'h10, "R3 date kept");
  endtask

  task automatic t_midnight24;
    set_time(8'h23, 8'h59, 8'h59, 8'h07, 8'h15, 8'h03, 8'h21);
    run_en(TPS);
    check(3'd2, 8'h00, "R4 hour wrap");
    check(3'd4, 8'h16, "R4 date step");
    check(3'd3, 8'h01, "R9 wday wrap");
  endtask

  task automatic t_twelve_hour;
    set_time(8'h51, 8'h59, 8'h59, 8'h03, 8'h05, 8'h07, 8'h22);
    run_en(TPS);
    check(3'd2, 8'h72, "R5 11AM to 12PM");
    check(3'd4, 8'h05, "R5 noon keeps date");
    set_time(8'h72, 8'h59, 8'h59, 8'h03, 8'h05, 8'h07, 8'h22);
    run_en(TPS);
    check(3'd2, 8'h61, "R5 12PM to 1PM");
    set_time(8'h52, 8'h59, 8'h59, 8'h03, 8'h05, 8'h07, 8'h22);
    run_en(TPS);
    check(3'd2, 8'h41, "R5 12AM to 1AM");
    set_time(8'h71, 8'h59, 8'h59, 8'h03, 8'h05, 8'h07, 8'h22);
    run_en(TPS);
    check(3'd2, 8'h52, "R5 11PM to 12AM");
    check(3'd4, 8'h06, "R5 midnight date");
    check(3'd3, 8'h04, "R9 wday step");
  endtask

  task automatic t_month_len;
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h04, 8'h21);
    run_en(TPS);
    check(3'd4, 8'h01, "R6 30-day wrap");
    check(3'd5, 8'h05, "R6 month step");
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h30, 8'h05, 8'h21);
    run_en(TPS);
    check(3'd4, 8'h31, "R6 31-day month");
  endtask

  task automatic t_february;
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h24);
    run_en(TPS);
    check(3'd4, 8'h29, "R7 leap 28 to 29");
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h23);
    run_en(TPS);
    check(3'd4, 8'h01, "R7 common wrap");
    check(3'd5, 8'h03, "R7 to march");
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h29, 8'h02, 8'h00);
    run_en(TPS);
    check(3'd4, 8'h01, "R7 year 00 leap wrap");
    set_time(8'h23, 8'h59, 8'h59, 8'h01, 8'h28, 8'h02, 8'h16);
    run_en(TPS);
    check(3'd4, 8'h29, "R7 odd tens leap");
  endtask

  task automatic t_year_roll;
    set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h99);
    run_en(TPS);
    check(3'd5, 8'h01, "R8 month wrap");
    check(3'd6, 8'h00, "R8 year wrap");
    set_time(8'h23, 8'h59, 8'h59, 8'h05, 8'h31, 8'h12, 8'h19);
    run_en(TPS);
    check(3'd6, 8'h20, "R8 year step");
  endtask

  task automatic t_halt;
    set_time(8'h00, 8'h00, 8'h10, 8'h01, 8'h01, 8'h01, 8'h00);
    wr_reg(3'd7, 8'h80);
    run_en(2 * TPS);
    check(3'd0, 8'h10, "R11 halted");
    check(3'd7, 8'h80, "R11 ctrl readback");
    wr_reg(3'd7, 8'h00);
    run_en(TPS);
    check(3'd0, 8'h11, "R11 resume");
  endtask

  task automatic t_sec_write_presc;
    set_time(8'h00, 8'h00, 8'h20, 8'h01, 8'h01, 8'h01, 8'h00);
    run_en(TPS - 3);
    wr_reg(3'd0, 8'h40);
    run_en(TPS - 1);
    check(3'd0, 8'h40, "R12 full second after write");
    run_en(1);
    check(3'd0, 8'h41, "R12 tick after clear");
  endtask

  task automatic t_write_while_counting;
    set_time(8'h05, 8'h10, 8'h59, 8'h02, 8'h12, 8'h08, 8'h25);
    run_en(TPS - 1);
    @(negedge clk);
    osc_en = 1'b1; wr = 1'b1; addr = 3'd1; wdata = 8'h30;
    @(negedge clk);
    osc_en = 1'b0; wr = 1'b0;
    check(3'd0, 8'h00, "R13 sec still ticks");
    check(3'd1, 8'h30, "R13 write wins");
    check(3'd2, 8'h05, "R13 hour kept");
    run_en(TPS - 1);
    @(negedge clk);
    osc_en = 1'b1; wr = 1'b1; addr = 3'd6; wdata = 8'h42;
    @(negedge clk);
    osc_en = 1'b0; wr = 1'b0;
    check(3'd6, 8'h42, "R13 year written");
    check(3'd0, 8'h01, "R13 sec advanced");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; osc_en = 1'b0; wr = 1'b0; addr = 3'd0; wdata = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_seconds;
    t_minute_carry;
    t_midnight24;
    t_twelve_hour;
    t_month_len;
    t_february;
    t_year_roll;
    t_halt;
    t_sec_write_presc;
    t_write_while_counting;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule